// File: doc/BRIEF.md
# Sleep Wake Controller

This block decides when the processor core stops and restarts its clock around a low-power sleep. Software arms sleep with an enable bit and chooses a depth with a 2-bit mode code. The sleep itself starts when the core issues a sleep-instruction strobe. While the core sleeps, the block drives a CPU clock enable and a peripheral clock enable that match the chosen depth.

The block wakes the core when an unmasked interrupt request arrives or when a reset request arrives. On an interrupt wake it flags that the core must service the interrupt and then continue at the instruction after the sleep. On a reset wake it flags a restart from the reset vector. The wake is immediate: the CPU clock enable rises in the same cycle as the wake cause. No architectural state is touched, so registers, memory and I/O keep their values across a sleep.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first sleep entry, `asleep`, `resumeNext` and `rstWake` are 0, and `cpuClkEn` and `periClkEn` are 1.
- R2: When the core is awake and `sleepStrobe` is 1, the core enters sleep at the next clock edge only if `sleepEn` is 1 in that same cycle. A strobe with `sleepEn` at 0 leaves `asleep` at 0.
- R3: Mode codes 00 and 01 select Idle. While asleep in Idle with no wake cause, `cpuClkEn` is 0 and `periClkEn` stays 1.
- R4: Mode code 10 selects Power-down and 11 selects Power-save. While asleep in either mode with no wake cause, both `cpuClkEn` and `periClkEn` are 0.
- R5: While asleep, an interrupt line whose request bit and mask bit are both 1 raises `cpuClkEn`, `periClkEn` and `resumeNext` in that same cycle. `asleep` is 0 after the next edge, so `resumeNext` lasts one cycle.
- R6: While asleep, a request on a line whose mask bit is 0 wakes nothing. All outputs keep their sleeping values.
- R7: While asleep, `rstReq` at 1 raises `cpuClkEn`, `periClkEn` and `rstWake` in that cycle and holds `resumeNext` at 0, even when an enabled interrupt is also pending. `asleep` is 0 after the next edge.
- R8: An enabled interrupt request or `rstReq` in the same cycle as an armed sleep strobe cancels the entry, and `asleep` stays 0.
- R9: While awake, `resumeNext` and `rstWake` stay 0 whatever the interrupt and reset requests do.
- R10: The mode code is captured at entry. Changing `sleepMode` while asleep does not change `periClkEn`.
- R11: A sleep strobe while already asleep has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the block |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sleepEn | input | 1 | Sleep arm bit from the control register |
| sleepMode | input | 2 | Sleep depth code (00/01 Idle, 10 Power-down, 11 Power-save) |
| sleepStrobe | input | 1 | One-cycle strobe marking execution of a sleep instruction |
| irqReq | input | NUM_IRQ | Interrupt request lines |
| irqMask | input | NUM_IRQ | Interrupt enable per line |
| rstReq | input | 1 | Core reset request |
| cpuClkEn | output | 1 | Clock enable for the CPU core |
| periClkEn | output | 1 | Clock enable for peripherals |
| asleep | output | 1 | Core is sleeping |
| resumeNext | output | 1 | One-cycle pulse: interrupt wake, resume after the sleep instruction |
| rstWake | output | 1 | One-cycle pulse: reset wake, restart at the reset vector |

## Verification
Directed sequences first run each mode code through a full entry and a wake. These show whether Idle keeps the peripheral clock while the two deep codes gate it, and whether 01 behaves like 00. Further directed sequences set wake causes against each other: masked against unmasked interrupt lines, reset against an interrupt in the same cycle, and each cause arriving together with the strobe. These separate wake priority from entry cancellation. A long random phase then mixes strobes, enable bits, mode changes while asleep and sparse requests. On every cycle it checks all five outputs against a behavioural model, which exposes any wrong cycle of wake or entry.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE     = 2'b00,
    MODE_IDLE_ALT = 2'b01,
    MODE_PDOWN    = 2'b10,
    MODE_PSAVE    = 2'b11
  } slpMode_e;

  // Strobes and level handed from control to datapath
  typedef struct packed {
    logic enter;
    logic wakeIrq;
    logic wakeRst;
    logic asleep;
  } slpCtl_t;

  // Only the upper code bit selects a deep mode that gates peripherals
  function automatic logic keepsPeri(slpMode_e m);
    return ~m[1];
  endfunction

endpackage

// File: rtl/slp_datapath.sv
module slp_datapath
  import slp_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqMask,
  input  logic [1:0]         sleepModeIn,
  input  slpCtl_t            ctl,
  output logic               anyIrq,
  output logic               cpuClkEn,
  output logic               periClkEn
);

  logic [NUM_IRQ-1:0] liveIrq;
  slpMode_e           modeReg;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : gLine
      assign liveIrq[g] = irqReq[g] & irqMask[g];
    end
  endgenerate

  assign anyIrq = |liveIrq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         modeReg <= MODE_IDLE;
    else if (ctl.enter) modeReg <= slpMode_e'(sleepModeIn);
  end

  always_comb begin
    cpuClkEn  = !ctl.asleep || ctl.wakeIrq || ctl.wakeRst;
    periClkEn = cpuClkEn || keepsPeri(modeReg);
  end

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.asleep && !ctl.enter) |=> $stable(modeReg));

  // R4
  deep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.asleep && modeReg[1] && !anyIrq && !ctl.wakeRst) |-> (!periClkEn && !cpuClkEn));

  // R3
  idle_peri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.asleep && !modeReg[1]) |-> periClkEn);

endmodule

// File: rtl/slp_control.sv
module slp_control
  import slp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sleepEn,
  input  logic    sleepStrobe,
  input  logic    anyIrq,
  input  logic    rstReq,
  output slpCtl_t ctl
);

  typedef enum logic {ST_AWAKE = 1'b0, ST_ASLEEP = 1'b1} state_e;
  state_e state;

  always_comb begin
    ctl.asleep  = (state == ST_ASLEEP);
    ctl.enter   = !ctl.asleep && sleepStrobe && sleepEn && !anyIrq && !rstReq;
    ctl.wakeRst = ctl.asleep && rstReq;
    ctl.wakeIrq = ctl.asleep && anyIrq && !rstReq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          state <= ST_AWAKE;
    else if (ctl.enter)                  state <= ST_ASLEEP;
    else if (ctl.wakeIrq || ctl.wakeRst) state <= ST_AWAKE;
  end

  // R9
  awake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.asleep |-> (!ctl.wakeIrq && !ctl.wakeRst));

  // R5
  irq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wakeIrq |=> (!ctl.asleep && !ctl.wakeIrq));

  // R7
  rst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wakeRst |=> !ctl.asleep);

  // R7
  rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.wakeRst && ctl.wakeIrq));

  // R2
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.asleep && !sleepEn) |=> !ctl.asleep);

  // R8
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.asleep && (anyIrq || rstReq)) |=> !ctl.asleep);

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import slp_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleepEn,
  input  logic [1:0]         sleepMode,
  input  logic               sleepStrobe,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqMask,
  input  logic               rstReq,
  output logic               cpuClkEn,
  output logic               periClkEn,
  output logic               asleep,
  output logic               resumeNext,
  output logic               rstWake
);

  slpCtl_t ctl;
  logic    anyIrq;

  slp_control uCtl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleepEn    (sleepEn),
    .sleepStrobe(sleepStrobe),
    .anyIrq     (anyIrq),
    .rstReq     (rstReq),
    .ctl        (ctl)
  );

  slp_datapath #(.NUM_IRQ(NUM_IRQ)) uDp (
    .clk        (clk),
    .rst_n      (rst_n),
    .irqReq     (irqReq),
    .irqMask    (irqMask),
    .sleepModeIn(sleepMode),
    .ctl        (ctl),
    .anyIrq     (anyIrq),
    .cpuClkEn   (cpuClkEn),
    .periClkEn  (periClkEn)
  );

  assign asleep     = ctl.asleep;
  assign resumeNext = ctl.wakeIrq;
  assign rstWake    = ctl.wakeRst;

endmodule

// File: tb/tb_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_wake_ctrl;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sleepEn = 1'b0;
  logic [1:0]   sleepMode = 2'b00;
  logic         sleepStrobe = 1'b0;
  logic [N-1:0] irqReq = '0;
  logic [N-1:0] irqMask = '0;
  logic         rstReq = 1'b0;
  logic cpuClkEn, periClkEn, asleep, resumeNext, rstWake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit refAsleep = 1'b0;
  int refMode = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.NUM_IRQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .sleepEn(sleepEn), .sleepMode(sleepMode),
    .sleepStrobe(sleepStrobe), .irqReq(irqReq), .irqMask(irqMask), .rstReq(rstReq),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .asleep(asleep),
    .resumeNext(resumeNext), .rstWake(rstWake));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string tag);
    bit irq, ex, expCpu, expPeri, expRes, expRw;
    irq     = |(irqReq & irqMask);
    expCpu  = !refAsleep || rstReq || irq;
    expPeri = expCpu || (refMode < 2);
    expRes  = refAsleep && irq && !rstReq;
    expRw   = refAsleep && rstReq;
    ex      = refAsleep;
    chk(asleep === ex, tag, "asleep", int'(asleep), int'(ex));
    chk(cpuClkEn === expCpu, tag, "cpuClkEn", int'(cpuClkEn), int'(expCpu));
    chk(periClkEn === expPeri, tag, "periClkEn", int'(periClkEn), int'(expPeri));
    chk(resumeNext === expRes, tag, "resumeNext", int'(resumeNext), int'(expRes));
    chk(rstWake === expRw, tag, "rstWake", int'(rstWake), int'(expRw));
  endtask

  function automatic string autoTag();
    bit irq = |(irqReq & irqMask);
    if (refAsleep) begin
      if (rstReq) return "R7";
      if (irq) return "R5";
      if (|irqReq) return "R6";
      if (sleepStrobe) return "R11";
      return (refMode < 2) ? "R3" : "R4";
    end
    if (sleepStrobe) return (irq || rstReq) ? "R8" : "R2";
    return "R9";
  endfunction

  task automatic step(input bit en, input bit stb, input logic [1:0] md,
                      input logic [N-1:0] rq, input logic [N-1:0] mk,
                      input bit rr, input string tag);
    bit irq;
    @(negedge clk);
    sleepEn = en; sleepStrobe = stb; sleepMode = md;
    irqReq = rq; irqMask = mk; rstReq = rr;
    #1;
    compareAll(tag == "" ? autoTag() : tag);
    irq = |(rq & mk);
    @(posedge clk);
    if (!refAsleep) begin
      if (stb && en && !irq && !rr) begin refAsleep = 1'b1; refMode = int'(md); end
    end else if (rr || irq) begin
      refAsleep = 1'b0;
    end
  endtask

  task automatic quiet(input int n, input logic [1:0] md, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, md, '0, 8'hFF, 1'b0, tag);
  endtask

  initial begin
    #200;
    // R1: outputs during reset
    compareAll("R1");
    @(negedge clk); rst_n = 1'b1;
    quiet(3, 2'b00, "R1");

    // R9: requests while awake give no pulses
    step(1'b0, 1'b0, 2'b00, 8'h01, 8'h01, 1'b0, "R9");
    step(1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 1'b1, "R9");

    // R2: strobe without arm bit
    step(1'b0, 1'b1, 2'b10, '0, 8'hFF, 1'b0, "R2");
    quiet(2, 2'b10, "R2");

    // R3: Idle 00, then interrupt wake R5
    step(1'b1, 1'b1, 2'b00, '0, 8'hFF, 1'b0, "R2");
    quiet(3, 2'b00, "R3");
    step(1'b1, 1'b0, 2'b00, 8'h10, 8'h10, 1'b0, "R5");
    quiet(2, 2'b00, "R5");

    // R3: code 01 behaves as Idle
    step(1'b1, 1'b1, 2'b01, '0, 8'hFF, 1'b0, "R3");
    quiet(2, 2'b01, "R3");
    step(1'b1, 1'b0, 2'b01, 8'h80, 8'hFF, 1'b0, "R5");

    // R4: Power-down, masked request R6, mode change R10, strobe R11
    step(1'b1, 1'b1, 2'b10, '0, 8'h0F, 1'b0, "R4");
    quiet(2, 2'b10, "R4");
    step(1'b1, 1'b0, 2'b10, 8'hF0, 8'h0F, 1'b0, "R6");
    step(1'b1, 1'b0, 2'b00, '0, 8'h0F, 1'b0, "R10");
    step(1'b1, 1'b0, 2'b01, '0, 8'h0F, 1'b0, "R10");
    step(1'b1, 1'b1, 2'b00, '0, 8'h0F, 1'b0, "R11");
    step(1'b1, 1'b0, 2'b00, '0, 8'h0F, 1'b0, "R11");
    // R7: reset wins over a pending interrupt
    step(1'b1, 1'b0, 2'b10, 8'h01, 8'h0F, 1'b1, "R7");
    quiet(2, 2'b10, "R7");

    // R4: Power-save, plain reset wake R7
    step(1'b1, 1'b1, 2'b11, '0, 8'hFF, 1'b0, "R4");
    quiet(2, 2'b11, "R4");
    step(1'b1, 1'b0, 2'b11, '0, 8'hFF, 1'b1, "R7");
    quiet(1, 2'b11, "R7");

    // R8: wake causes coincident with strobe cancel entry
    step(1'b1, 1'b1, 2'b00, 8'h02, 8'h02, 1'b0, "R8");
    quiet(2, 2'b00, "R8");
    step(1'b1, 1'b1, 2'b10, '0, 8'hFF, 1'b1, "R8");
    quiet(2, 2'b10, "R8");
    // masked line at strobe does not cancel
    step(1'b1, 1'b1, 2'b10, 8'h02, 8'h00, 1'b0, "R8");
    quiet(1, 2'b10, "R4");
    step(1'b1, 1'b0, 2'b10, 8'h04, 8'h04, 1'b0, "R5");

    // random mix, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] rq;
      rq = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0),
           2'($urandom), rq, N'($urandom), 1'($urandom_range(0, 19) == 0), "");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule